// File: doc/BRIEF.md
# EEPROM register access controller

This block lets a small CPU reach a 512-byte non-volatile byte store through four I/O-mapped byte registers: an address register split into a high and a low byte, a data register and a control register. The CPU reads a byte by pulsing the read bit of the control register, is held for a few cycles, and then finds the byte in the data register. To write, software places the address and the byte, arms the write with a separate arming bit, and then pulses the write bit. The write then finishes on its own timer while software polls the write bit or waits for the ready interrupt.

The arming bit drops by itself a few cycles after it is set, so a stray jump into a lone write strobe cannot change the store. The store is modelled as an internal register array. A cycle count parameter stands in for the long programming time of the real cells.

Top module: `nvs_regctl`

## Requirements
- R1: After reset the data register and the control register read 0x00, `cpu_stall` is 0 and `irq` is 0.
- R2: The high address byte (I/O address 0x1F) returns address bit 8 in bit 0 and zeros in bits 7..1. The low address byte (0x1E) holds address bits 7..0. Writes to the high byte keep only bit 0.
- R3: The control register sits at 0x1C. Bit 3 is the ready-interrupt enable, bit 2 is arm, bit 1 is write/busy and bit 0 is read. Bits 7..4 always read 0, and writing them has no effect. The data register sits at 0x1D.
- R4: Writing 1 to bit 2 sets arm. Arm reads 1 for exactly 4 cycles and then clears itself. Writing 0 to bit 2 does not clear it. Writing 1 again while it is set restarts the 4 cycles.
- R5: A write strobe (bit 1) while arm is clear changes no stored byte, does not set the busy bit and does not stall the CPU.
- R6: An armed write strobe while idle stores the data register at the current address. The busy bit reads 1 for exactly WR_CYCLES cycles and `cpu_stall` is high for the first 2 of them.
- R7: A read strobe (bit 0) while idle sets bit 0 and `cpu_stall` for exactly 4 cycles. Then the data register holds the byte at the address and bit 0 reads 0.
- R8: While a write is busy or a read is pending, new read and write strobes are ignored.
- R9: `irq` is high exactly when the interrupt enable is 1 and no write is busy.
- R10: A write strobe that arrives after arm has expired is ignored.
- R11: If one control write carries both an accepted write strobe and a read strobe, the write starts and the read is dropped.
- R12: Changes to the address or data register during a busy write do not affect the byte being stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read select; the read has no side effect |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data; 0 when not selected |
| cpu_stall | output | 1 | CPU hold request during access |
| irq | output | 1 | Level ready interrupt request |

## Verification
Writes are tried in several forms: properly armed, unarmed, after the arm has expired, during a busy write, and combined with a read strobe in the same control write. This tells the gate's timing apart from its mere presence. Busy, arm and stall lengths are measured by counting cycles at the register port, so an off-by-one in any counter shows up. Readback after changing the address and data during a busy write separates latching at the start of a write from sampling at its end.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    localparam int IO_AW = 6;
    typedef logic [IO_AW-1:0] io_addr_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_AHI,
        SEL_ALO,
        SEL_DATA,
        SEL_CTRL
    } reg_sel_e;

    // Control register layout, MSB first: ie, arm, wr, rd
    typedef struct packed {
        logic ie;
        logic arm;
        logic wr;
        logic rd;
    } ctrl_t;

    function automatic reg_sel_e decode_sel(
        input io_addr_t a,
        input io_addr_t a_hi,
        input io_addr_t a_lo,
        input io_addr_t a_dat,
        input io_addr_t a_ctl
    );
        if (a == a_hi)  return SEL_AHI;
        if (a == a_lo)  return SEL_ALO;
        if (a == a_dat) return SEL_DATA;
        if (a == a_ctl) return SEL_CTRL;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvs_arm_timer.sv
module nvs_arm_timer #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_set,
    output logic armed
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            left  <= '0;
        end else if (arm_set) begin
            armed <= 1'b1;
            left  <= CW'(HOLD - 1);
        end else if (armed) begin
            if (left == '0) armed <= 1'b0;
            else            left  <= left - 1'b1;
        end
    end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq #(
    parameter int AW        = 9,
    parameter int DW        = 8,
    parameter int WR_CYCLES = 40,
    parameter int RD_STALL  = 4,
    parameter int WR_STALL  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_go,
    input  logic          rd_go,
    input  logic [AW-1:0] cur_addr,
    input  logic [DW-1:0] cur_data,
    output logic          wr_busy,
    output logic          rd_busy,
    output logic          rd_done,
    output logic          stall,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] mem_raddr
);
    localparam int WCW  = $clog2(WR_CYCLES);
    localparam int RCW  = $clog2(RD_STALL + 1);
    localparam int SMAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
    localparam int SCW  = $clog2(SMAX + 1);

    logic [WCW-1:0] wr_left;
    logic [RCW-1:0] rd_left;
    logic [SCW-1:0] stall_left;

    // Self-timed write job
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_busy <= 1'b0;
            wr_left <= '0;
        end else if (wr_go) begin
            wr_busy <= 1'b1;
            wr_left <= WCW'(WR_CYCLES - 1);
        end else if (wr_busy) begin
            if (wr_left == '0) wr_busy <= 1'b0;
            else               wr_left <= wr_left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem_waddr <= cur_addr;
            mem_wdata <= cur_data;
        end
        if (rd_go) mem_raddr <= cur_addr;
    end

    assign mem_we = wr_busy && (wr_left == '0);

    // Read job
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_busy <= 1'b0;
            rd_left <= '0;
        end else if (rd_go) begin
            rd_busy <= 1'b1;
            rd_left <= RCW'(RD_STALL);
        end else if (rd_busy) begin
            rd_left <= rd_left - 1'b1;
            if (rd_done) rd_busy <= 1'b0;
        end
    end

    assign rd_done = rd_busy && (rd_left == RCW'(1));

    // Shared CPU hold counter
    always_ff @(posedge clk) begin
        if (rst)                     stall_left <= '0;
        else if (rd_go)              stall_left <= SCW'(RD_STALL);
        else if (wr_go)              stall_left <= SCW'(WR_STALL);
        else if (stall_left != '0)   stall_left <= stall_left - 1'b1;
    end

    assign stall = (stall_left != '0);
endmodule

// File: rtl/nvs_regctl.sv
module nvs_regctl
    import nvs_pkg::*;
#(
    parameter int       AW        = 9,
    parameter int       DW        = 8,
    parameter int       WR_CYCLES = 40,
    parameter int       ARM_HOLD  = 4,
    parameter int       RD_STALL  = 4,
    parameter int       WR_STALL  = 2,
    parameter io_addr_t A_AHI     = 6'h1F,
    parameter io_addr_t A_ALO     = 6'h1E,
    parameter io_addr_t A_DAT     = 6'h1D,
    parameter io_addr_t A_CTL     = 6'h1C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [DW-1:0]    io_wdata,
    output logic [DW-1:0]    io_rdata,
    output logic             cpu_stall,
    output logic             irq
);
    localparam int HI_W = AW - 8;

    reg_sel_e      sel;
    logic          wr_ahi, wr_alo, wr_dat, wr_ctl;
    ctrl_t         wctl, view;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          ie_q;
    logic          armed, idle, wr_go, rd_go;
    logic          wr_busy, rd_busy, rd_done, stall;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    assign sel    = decode_sel(io_addr, A_AHI, A_ALO, A_DAT, A_CTL);
    assign wr_ahi = io_wr && (sel == SEL_AHI);
    assign wr_alo = io_wr && (sel == SEL_ALO);
    assign wr_dat = io_wr && (sel == SEL_DATA);
    assign wr_ctl = io_wr && (sel == SEL_CTRL);
    assign wctl   = ctrl_t'(io_wdata[3:0]);

    // Address register: no reset, software must load it first
    always_ff @(posedge clk) begin
        if (wr_ahi) addr_q[AW-1:8] <= io_wdata[HI_W-1:0];
        if (wr_alo) addr_q[7:0]    <= io_wdata[7:0];
    end

    always_ff @(posedge clk) begin
        if (rst)          data_q <= '0;
        else if (rd_done) data_q <= mem_rdata;
        else if (wr_dat)  data_q <= io_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         ie_q <= 1'b0;
        else if (wr_ctl) ie_q <= wctl.ie;
    end

    assign idle  = !wr_busy && !rd_busy;
    assign wr_go = wr_ctl && wctl.wr && armed && idle;
    assign rd_go = wr_ctl && wctl.rd && idle && !wr_go;

    nvs_arm_timer #(.HOLD(ARM_HOLD)) u_arm (
        .clk     (clk),
        .rst     (rst),
        .arm_set (wr_ctl && wctl.arm),
        .armed   (armed)
    );

    nvs_seq #(
        .AW(AW), .DW(DW), .WR_CYCLES(WR_CYCLES),
        .RD_STALL(RD_STALL), .WR_STALL(WR_STALL)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .cur_addr  (addr_q),
        .cur_data  (data_q),
        .wr_busy   (wr_busy),
        .rd_busy   (rd_busy),
        .rd_done   (rd_done),
        .stall     (stall),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr)
    );

    nvs_array #(.AW(AW), .DW(DW)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign view = '{ie: ie_q, arm: armed, wr: wr_busy, rd: rd_busy};

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            unique case (sel)
                SEL_AHI:  io_rdata[HI_W-1:0] = addr_q[AW-1:8];
                SEL_ALO:  io_rdata[7:0]      = addr_q[7:0];
                SEL_DATA: io_rdata           = data_q;
                SEL_CTRL: io_rdata[3:0]      = view;
                default:  io_rdata           = '0;
            endcase
        end
    end

    assign cpu_stall = stall;
    assign irq       = ie_q && !wr_busy;
endmodule

// File: rtl/nvs_regctl_chk.sv
module nvs_regctl_chk
    import nvs_pkg::*;
#(
    parameter int       ARM_HOLD = 4,
    parameter io_addr_t A_AHI    = 6'h1F,
    parameter io_addr_t A_CTL    = 6'h1C
) (
    input logic     clk,
    input logic     rst,
    input logic     io_rd,
    input logic     io_wr,
    input io_addr_t io_addr,
    input logic     arm_wr_bit,
    input logic [7:0] io_rdata,
    input logic     cpu_stall,
    input logic     irq,
    input logic     wr_busy,
    input logic     rd_busy,
    input logic     armed,
    input logic     ie_q
);
    logic [7:0] arm_run;

    always_ff @(posedge clk) begin
        if (rst)                                         arm_run <= '0;
        else if (io_wr && io_addr == A_CTL && arm_wr_bit) arm_run <= 8'd1;
        else if (armed && arm_run != 8'hFF)              arm_run <= arm_run + 8'd1;
        else if (!armed)                                 arm_run <= '0;
    end

    // R4
    arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (arm_run <= 8'(ARM_HOLD)));

    // R5
    arm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_busy) |-> $past(armed));

    // R7
    read_stall_chk: assert property (@(posedge clk) disable iff (rst)
        rd_busy |-> cpu_stall);

    // R8
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_busy) |-> !$past(wr_busy));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        wr_busy |-> !irq);

    // R9
    irq_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(wr_busy) && ie_q) |-> irq);

    // R2
    hi_resv_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == A_AHI) |-> (io_rdata[7:1] == 7'd0));

    // R3
    ctl_resv_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == A_CTL) |-> (io_rdata[7:4] == 4'd0));
endmodule

bind nvs_regctl nvs_regctl_chk #(
    .ARM_HOLD (ARM_HOLD),
    .A_AHI    (A_AHI),
    .A_CTL    (A_CTL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .arm_wr_bit (io_wdata[2]),
    .io_rdata   (io_rdata),
    .cpu_stall  (cpu_stall),
    .irq        (irq),
    .wr_busy    (wr_busy),
    .rd_busy    (rd_busy),
    .armed      (armed),
    .ie_q       (ie_q)
);

// File: tb/nvs_regctl_test.sv
`timescale 1ns/1ps
module nvs_regctl_test;
    localparam int W   = 24;
    localparam int ARM = 4;
    localparam int AHI = 'h1F, ALO = 'h1E, DAT = 'h1D, CTL = 'h1C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] io_addr = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       cpu_stall, irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nvs_regctl #(.WR_CYCLES(W)) uut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_stall(cpu_stall), .irq(irq)
    );

    // Behavioural reference: counters of remaining cycles and a sparse store
    int mem [int];
    int m_addr = 0, m_dr = 0, m_ie = 0;
    int m_arm = 0, m_wleft = 0, m_rleft = 0, m_stall = 0;
    int m_waddr = 0, m_wdat = 0, m_raddr = 0;
    bit m_idle, m_armed;

    always @(posedge clk) begin
        if (rst) begin
            m_dr = 0; m_ie = 0; m_arm = 0; m_wleft = 0; m_rleft = 0; m_stall = 0;
        end else begin
            m_idle  = (m_wleft == 0) && (m_rleft == 0);
            m_armed = (m_arm > 0);
            if (m_stall > 0) m_stall--;
            if (m_arm > 0) m_arm--;
            if (m_rleft > 0) begin
                m_rleft--;
                if (m_rleft == 0) m_dr = mem.exists(m_raddr) ? mem[m_raddr] : 0;
            end
            if (m_wleft > 0) begin
                m_wleft--;
                if (m_wleft == 0) mem[m_waddr] = m_wdat;
            end
            if (io_wr) begin
                if (io_addr == AHI) m_addr = (m_addr & 255) | ((int'(io_wdata) & 1) << 8);
                else if (io_addr == ALO) m_addr = (m_addr & 256) | int'(io_wdata);
                else if (io_addr == DAT) m_dr = int'(io_wdata);
                else if (io_addr == CTL) begin
                    m_ie = int'(io_wdata[3]);
                    if (io_wdata[2]) m_arm = ARM;
                    if (io_wdata[1] && m_armed && m_idle) begin
                        m_wleft = W; m_stall = 2; m_waddr = m_addr; m_wdat = m_dr;
                    end else if (io_wdata[0] && m_idle) begin
                        m_rleft = 4; m_stall = 4; m_raddr = m_addr;
                    end
                end
            end
        end
    end

    function automatic int exp_rd(int a);
        if (a == AHI) return (m_addr >> 8) & 1;
        if (a == ALO) return m_addr & 255;
        if (a == DAT) return m_dr;
        if (a == CTL) return (m_ie << 3) | (int'(m_arm > 0) << 2)
                           | (int'(m_wleft > 0) << 1) | int'(m_rleft > 0);
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rdv(input int a, output int v);
        io_addr = 6'(a); io_rd = 1'b1;
        #1;
        v = int'(io_rdata);
        io_rd = 1'b0;
    endtask

    task automatic rd_chk(input int a, input string req, input int lit);
        int v;
        rdv(a, v);
        chk(req, v, exp_rd(a));
        if (lit >= 0) chk(req, v, lit);
    endtask

    task automatic wr(input int a, input int d);
        io_addr = 6'(a); io_wdata = 8'(d); io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_wleft > 0 || m_rleft > 0) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Per-cycle comparison of the hold and interrupt outputs
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6/R7 cpu_stall", int'(cpu_stall), int'(m_stall > 0));
            chk("R9 irq", int'(irq), int'(m_ie != 0 && m_wleft == 0));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        int n, v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(CTL, "R1", 0);
        rd_chk(DAT, "R1", 0);
        chk("R1 stall", int'(cpu_stall), 0);
        chk("R1 irq", int'(irq), 0);

        // R2 split address
        wr(AHI, 'hFF); wr(ALO, 'h20);
        rd_chk(AHI, "R2", 1);
        rd_chk(ALO, "R2", 'h20);
        wr(AHI, 'h00);
        rd_chk(AHI, "R2", 0);

        // R3 reserved control bits, R9 enable
        wr(CTL, 'hF8);
        rd_chk(CTL, "R3", 'h08);
        chk("R9 irq idle", int'(irq), 1);
        wr(CTL, 'h00);
        chk("R9 irq off", int'(irq), 0);

        // R6 armed write of 0x3C to 0x020
        wr(DAT, 'h3C); wr(CTL, 'h04);
        rd_chk(CTL, "R4", 'h04);
        wr(CTL, 'h02);
        rdv(CTL, v); chk("R6 busy set", v & 2, 2);
        chk("R6 stall", int'(cpu_stall), 1);
        n = 0;
        begin
            rdv(CTL, v);
            while ((v & 2) != 0) begin n++; @(negedge clk); rdv(CTL, v); end
        end
        chk("R6 busy length", n, W);

        // R7 read back
        wr(CTL, 'h01);
        n = 0;
        while (cpu_stall) begin n++; @(negedge clk); end
        chk("R7 stall length", n, 4);
        rd_chk(DAT, "R7", 'h3C);
        rd_chk(CTL, "R7", 0);

        // R5 unarmed strobe ignored
        wr(DAT, 'h77); wr(CTL, 'h02);
        rd_chk(CTL, "R5", 0);
        chk("R5 no stall", int'(cpu_stall), 0);
        wr(CTL, 'h01); repeat (5) @(negedge clk);
        rd_chk(DAT, "R5", 'h3C);

        // R10 strobe after arm expired
        wr(DAT, 'h55); wr(CTL, 'h04);
        repeat (5) @(negedge clk);
        wr(CTL, 'h02);
        rd_chk(CTL, "R10", 0);
        wr(CTL, 'h01); repeat (5) @(negedge clk);
        rd_chk(DAT, "R10", 'h3C);

        // R4 arm length, zero write, reload
        wr(CTL, 'h04); wr(CTL, 'h00);
        rd_chk(CTL, "R4 zero keeps", 'h04);
        repeat (5) @(negedge clk);
        wr(CTL, 'h04);
        n = 0;
        begin
            rdv(CTL, v);
            while ((v & 4) != 0) begin n++; @(negedge clk); rdv(CTL, v); end
        end
        chk("R4 arm length", n, 4);
        wr(CTL, 'h04); @(negedge clk); wr(CTL, 'h04);
        n = 0;
        begin
            rdv(CTL, v);
            while ((v & 4) != 0) begin n++; @(negedge clk); rdv(CTL, v); end
        end
        chk("R4 reload length", n, 4);

        // R8, R12: busy write of 0x99 to 0x101, disturbances during busy
        wr(AHI, 'h01); wr(ALO, 'h01); wr(DAT, 'h99);
        wr(CTL, 'h04); wr(CTL, 'h0A);
        chk("R9 irq busy", int'(irq), 0);
        repeat (3) @(negedge clk);
        wr(CTL, 'h09);
        rdv(CTL, v); chk("R8 read ignored", v & 1, 0);
        chk("R8 no stall", int'(cpu_stall), 0);
        wr(CTL, 'h0C); wr(CTL, 'h0A);
        wr(DAT, 'h44); wr(ALO, 'h02);
        wait_idle();
        chk("R9 irq ready", int'(irq), 1);
        @(negedge clk);
        rd_chk(CTL, "R8", 'h08);
        wr(ALO, 'h01); wr(CTL, 'h01); repeat (5) @(negedge clk);
        rd_chk(DAT, "R12", 'h99);

        // R11 write wins over read
        wr(ALO, 'h03); wr(DAT, 'h5E); wr(CTL, 'h04); wr(CTL, 'h03);
        rdv(CTL, v); chk("R11 write only", v & 3, 2);
        wait_idle();
        wr(DAT, 'h00); wr(CTL, 'h01); repeat (5) @(negedge clk);
        rd_chk(DAT, "R11", 'h5E);

        done = 1;
        finish_up();
    end
endmodule